// File: doc/BRIEF.md
# Bus Clock Startup and Gating Controller

This block makes the bus timing for a small microcontroller from one source clock. It chooses one of two source rates: the source clock itself, or the source clock divided by two. It passes the chosen rate through two cascaded divide-by-two stages. The result is a bus strobe at one quarter of the selected rate. The strobe is one source cycle wide.

The bus strobe is not turned into gated clock nets. It is handed out as clock-enable pulses: one for the CPU and one for each peripheral. A five-state machine decides which enables may pulse:

- **STARTUP**: holds an internal reset after a power-on or low-voltage request.
- **RUN**: normal operation.
- **WAIT**: only peripherals marked for wait-mode operation keep pulsing.
- **STOP**: everything is quiet.
- **RECOVER**: counts a recovery timeout after a wake from stop.

The transitions are:

- Any reset request from any state goes to STARTUP and zeroes the shared counter.
- STARTUP goes to RUN after START_CYCLES cycles.
- RUN goes to STOP on a stop request. Stop wins over wait.
- RUN goes to WAIT on a wait request.
- WAIT goes to RUN on a wake.
- STOP goes to RECOVER on a wake.
- RECOVER goes to RUN after STOP_CYCLES cycles.

The divider flops are cleared in every state except RUN and WAIT. As a result, bus timing restarts from a fixed phase each time the clocks come back.

Top module: `busclk_gate_ctrl`

## Requirements
- R1: With src_sel_b = 1, the bus strobe runs at one quarter of the source clock. The strobe is seen on cpu_en in RUN. It is one cycle wide, and the first pulse comes in the 4th cycle after the enables are released (released at the move to RUN from STARTUP or RECOVER). It then repeats every 4 cycles.
- R2: With src_sel_b = 0, the selected source is half the source clock. The strobe then comes first in the 8th released cycle and repeats every 8 cycles.
- R3: After the last cycle in which por_req or lvi_req is high, sys_rst stays 1 for exactly START_CYCLES cycles. During that time cpu_en and every periph_en bit are 0.
- R4: A reset request that arrives during STARTUP restarts the count, so sys_rst stays high for START_CYCLES cycles after the new request.
- R5: A stop_req seen in RUN enters STOP on the next cycle, even if wait_req is also high. In STOP, all enables are 0 and sys_rst is 0 until wake.
- R6: A wake in STOP starts a recovery of exactly STOP_CYCLES cycles. During recovery all enables and sys_rst are 0. After recovery the block is in RUN and the strobe follows the phase of R1/R2 from that release.
- R7: A wait_req seen in RUN enters WAIT. In WAIT, cpu_en stays 0. periph_en[i] carries the bus strobe exactly when periph_wait_en[i] is 1. The divider phase continues without restart.
- R8: A wake in WAIT returns to RUN on the next cycle with no delay. cpu_en resumes on the continuing divider phase.
- R9: wake, stop_req and wait_req have no effect during STARTUP. wake has no effect in RUN.
- R10: A reset request in RUN, WAIT, STOP or RECOVER enters STARTUP on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| por_req | input | 1 | Power-on reset request, active high |
| lvi_req | input | 1 | Low-voltage reset request, active high |
| src_sel_b | input | 1 | Source select: 1 = source clock, 0 = source clock divided by two |
| stop_req | input | 1 | Stop-mode entry request |
| wait_req | input | 1 | Wait-mode entry request |
| wake | input | 1 | Interrupt/wake event |
| periph_wait_en | input | NUM_PERIPH | Per-peripheral enable for running in wait mode |
| sys_rst | output | 1 | Internal reset, high during startup count |
| cpu_en | output | 1 | CPU clock-enable strobe |
| periph_en | output | NUM_PERIPH | Peripheral clock-enable strobes |

## Verification
The bench builds the block with START_CYCLES = 32, STOP_CYCLES = 16 and NUM_PERIPH = 4. With these values, the exact length of the startup hold and of the stop recovery is compared cycle by cycle. A restart in the middle of startup, followed by a full re-count, fits in a short run. So do thousands of random mode changes, each of which passes many startup and recovery windows. Four peripherals are enough to cover mixed wait-enable patterns, where some enables pulse in WAIT and others stay silent.

// File: rtl/busclk_pkg.sv
package busclk_pkg;
    typedef enum logic [2:0] {
        ST_STARTUP = 3'd0,
        ST_RUN     = 3'd1,
        ST_WAIT    = 3'd2,
        ST_STOP    = 3'd3,
        ST_RECOVER = 3'd4
    } busclk_state_e;
endpackage

// File: rtl/busclk_div2.sv
// One divide-by-two stage working on enable pulses: passes every second input pulse.
module busclk_div2 (
    input  logic clk,
    input  logic clr,
    input  logic en_in,
    output logic en_out
);
    logic half_q;

    always_ff @(posedge clk) begin
        if (clr)
            half_q <= 1'b0;
        else if (en_in)
            half_q <= ~half_q;
    end

    assign en_out = en_in & half_q;
endmodule

// File: rtl/busclk_divider.sv
// Source-rate select followed by a cascade of divide-by-two stages.
module busclk_divider #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic clr,
    input  logic src_sel_b,
    output logic bus_stb
);
    logic half_rate;
    logic src_tick;
    logic [STAGES:0] chain;

    // Input A of the selector: source clock halved.
    busclk_div2 u_pre (
        .clk   (clk),
        .clr   (clr),
        .en_in (1'b1),
        .en_out(half_rate)
    );

    // Select = 1 passes input B (full source rate).
    assign src_tick = src_sel_b ? 1'b1 : half_rate;
    assign chain[0] = src_tick;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        busclk_div2 u_stage (
            .clk   (clk),
            .clr   (clr),
            .en_in (chain[g]),
            .en_out(chain[g+1])
        );
    end

    assign bus_stb = chain[STAGES];
endmodule

// File: rtl/busclk_seq.sv
// Mode sequencer: startup hold, run, wait, stop and stop recovery.
module busclk_seq
    import busclk_pkg::*;
#(
    parameter int START_CYCLES = 4096,
    parameter int STOP_CYCLES  = 4096,
    parameter int CNT_W        = 12
) (
    input  logic                 clk,
    input  logic                 por_req,
    input  logic                 lvi_req,
    input  logic                 stop_req,
    input  logic                 wait_req,
    input  logic                 wake,
    output busclk_state_e        state_o,
    output logic [CNT_W-1:0]     cnt_o,
    output logic                 sys_rst,
    output logic                 clocks_live,
    output logic                 cpu_run,
    output logic                 periph_wait
);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYCLES - 1);
    localparam logic [CNT_W-1:0] STOP_LAST  = CNT_W'(STOP_CYCLES - 1);

    busclk_state_e    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             rst_req;

    assign rst_req = por_req | lvi_req;

    // Next-state and counter logic.
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (rst_req) begin
            state_d = ST_STARTUP;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_STARTUP: begin
                    if (cnt_q == START_LAST) begin
                        state_d = ST_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                ST_RUN: begin
                    if (stop_req)
                        state_d = ST_STOP;
                    else if (wait_req)
                        state_d = ST_WAIT;
                end
                ST_WAIT: begin
                    if (wake)
                        state_d = ST_RUN;
                end
                ST_STOP: begin
                    if (wake) begin
                        state_d = ST_RECOVER;
                        cnt_d   = '0;
                    end
                end
                ST_RECOVER: begin
                    if (cnt_q == STOP_LAST) begin
                        state_d = ST_RUN;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: begin
                    state_d = ST_STARTUP;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        state_q <= state_d;
        cnt_q   <= cnt_d;
    end

    // Outputs decoded from state.
    always_comb begin
        sys_rst     = 1'b0;
        clocks_live = 1'b0;
        cpu_run     = 1'b0;
        periph_wait = 1'b0;
        unique case (state_q)
            ST_STARTUP: sys_rst = 1'b1;
            ST_RUN: begin
                clocks_live = 1'b1;
                cpu_run     = 1'b1;
            end
            ST_WAIT: begin
                clocks_live = 1'b1;
                periph_wait = 1'b1;
            end
            ST_STOP:    ;
            ST_RECOVER: ;
            default:    sys_rst = 1'b1;
        endcase
    end

    assign state_o = state_q;
    assign cnt_o   = cnt_q;
endmodule

// File: rtl/busclk_gate_ctrl.sv
module busclk_gate_ctrl
    import busclk_pkg::*;
#(
    parameter int START_CYCLES = 4096,
    parameter int STOP_CYCLES  = 4096,
    parameter int NUM_PERIPH   = 4,
    parameter int DIV_STAGES   = 2
) (
    input  logic                  clk,
    input  logic                  por_req,
    input  logic                  lvi_req,
    input  logic                  src_sel_b,
    input  logic                  stop_req,
    input  logic                  wait_req,
    input  logic                  wake,
    input  logic [NUM_PERIPH-1:0] periph_wait_en,
    output logic                  sys_rst,
    output logic                  cpu_en,
    output logic [NUM_PERIPH-1:0] periph_en
);
    localparam int MAX_CYC = (START_CYCLES > STOP_CYCLES) ? START_CYCLES : STOP_CYCLES;
    localparam int CNT_W   = (MAX_CYC > 1) ? $clog2(MAX_CYC) : 1;

    busclk_state_e    fsm_state;
    logic [CNT_W-1:0] fsm_cnt;
    logic             clocks_live;
    logic             cpu_run;
    logic             periph_wait;
    logic             bus_stb;

    busclk_seq #(
        .START_CYCLES(START_CYCLES),
        .STOP_CYCLES (STOP_CYCLES),
        .CNT_W       (CNT_W)
    ) u_seq (
        .clk        (clk),
        .por_req    (por_req),
        .lvi_req    (lvi_req),
        .stop_req   (stop_req),
        .wait_req   (wait_req),
        .wake       (wake),
        .state_o    (fsm_state),
        .cnt_o      (fsm_cnt),
        .sys_rst    (sys_rst),
        .clocks_live(clocks_live),
        .cpu_run    (cpu_run),
        .periph_wait(periph_wait)
    );

    busclk_divider #(
        .STAGES(DIV_STAGES)
    ) u_div (
        .clk      (clk),
        .clr      (~clocks_live),
        .src_sel_b(src_sel_b),
        .bus_stb  (bus_stb)
    );

    assign cpu_en = bus_stb & cpu_run;

    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_periph
        assign periph_en[p] = bus_stb & (cpu_run | (periph_wait & periph_wait_en[p]));
    end
endmodule

// File: rtl/busclk_gate_ctrl_chk.sv
module busclk_gate_ctrl_chk
    import busclk_pkg::*;
#(
    parameter int STOP_CYCLES = 4096,
    parameter int NUM_PERIPH  = 4,
    parameter int CNT_W       = 12
) (
    input logic                  clk,
    input logic                  por_req,
    input logic                  lvi_req,
    input logic                  wake,
    input logic                  sys_rst,
    input logic                  cpu_en,
    input logic [NUM_PERIPH-1:0] periph_en,
    input busclk_state_e         fsm_state,
    input logic [CNT_W-1:0]      fsm_cnt
);
    // R3
    rst_quiet_chk: assert property (@(posedge clk) disable iff (por_req || lvi_req)
        sys_rst |-> (!cpu_en && periph_en == '0));

    // R1
    strobe_single_chk: assert property (@(posedge clk) disable iff (por_req || lvi_req)
        cpu_en |=> !cpu_en);

    // R7
    wait_cpu_chk: assert property (@(posedge clk) disable iff (por_req || lvi_req)
        (fsm_state == ST_WAIT) |-> !cpu_en);

    // R5
    stop_quiet_chk: assert property (@(posedge clk) disable iff (por_req || lvi_req)
        (fsm_state == ST_STOP) |-> (!cpu_en && periph_en == '0 && !sys_rst));

    // R6
    recover_exit_chk: assert property (@(posedge clk) disable iff (por_req || lvi_req)
        (fsm_state == ST_RECOVER && fsm_cnt == CNT_W'(STOP_CYCLES - 1)) |=> (fsm_state == ST_RUN));

    // R8
    wake_wait_chk: assert property (@(posedge clk) disable iff (por_req || lvi_req)
        (fsm_state == ST_WAIT && wake) |=> (fsm_state == ST_RUN));
endmodule

bind busclk_gate_ctrl busclk_gate_ctrl_chk #(
    .STOP_CYCLES(STOP_CYCLES),
    .NUM_PERIPH (NUM_PERIPH),
    .CNT_W      (CNT_W)
) u_chk (
    .clk      (clk),
    .por_req  (por_req),
    .lvi_req  (lvi_req),
    .wake     (wake),
    .sys_rst  (sys_rst),
    .cpu_en   (cpu_en),
    .periph_en(periph_en),
    .fsm_state(fsm_state),
    .fsm_cnt  (fsm_cnt)
);

// File: tb/busclk_gate_ctrl_tb.sv
`timescale 1ns/1ps
module busclk_gate_ctrl_tb;
    localparam int START = 32;
    localparam int STOPC = 16;
    localparam int NP    = 4;

    localparam int M_ST  = 0;
    localparam int M_RUN = 1;
    localparam int M_WT  = 2;
    localparam int M_SP  = 3;
    localparam int M_RC  = 4;

    logic          clk = 1'b0;
    logic          por_req = 1'b1;
    logic          lvi_req = 1'b0;
    logic          src_sel_b = 1'b1;
    logic          stop_req = 1'b0;
    logic          wait_req = 1'b0;
    logic          wake = 1'b0;
    logic [NP-1:0] periph_wait_en = '0;
    logic          sys_rst;
    logic          cpu_en;
    logic [NP-1:0] periph_en;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference model state
    int m_mode = M_ST;
    int m_cnt  = 0;
    int m_n    = 0;

    always #2 clk = ~clk;

    busclk_gate_ctrl #(
        .START_CYCLES(START),
        .STOP_CYCLES (STOPC),
        .NUM_PERIPH  (NP)
    ) u_dut (
        .clk           (clk),
        .por_req       (por_req),
        .lvi_req       (lvi_req),
        .src_sel_b     (src_sel_b),
        .stop_req      (stop_req),
        .wait_req      (wait_req),
        .wake          (wake),
        .periph_wait_en(periph_wait_en),
        .sys_rst       (sys_rst),
        .cpu_en        (cpu_en),
        .periph_en     (periph_en)
    );

    function automatic bit exp_stb();
        bit live = (m_mode == M_RUN) || (m_mode == M_WT);
        if (!live) return 1'b0;
        if (src_sel_b) return (m_n % 4) == 3;
        return (m_n % 8) == 7;
    endfunction

    function automatic logic [NP-1:0] exp_periph();
        logic [NP-1:0] r = '0;
        bit s = exp_stb();
        for (int i = 0; i < NP; i++)
            r[i] = s && ((m_mode == M_RUN) || (m_mode == M_WT && periph_wait_en[i]));
        return r;
    endfunction

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h (t=%0t)", tag, what, act, exp, $time);
        end
    endtask

    task automatic model_update();
        bit old_live = (m_mode == M_RUN) || (m_mode == M_WT);
        m_n = old_live ? m_n + 1 : 0;
        if (por_req || lvi_req) begin
            m_mode = M_ST; m_cnt = 0;
        end else begin
            case (m_mode)
                M_ST:  if (m_cnt == START - 1) begin m_mode = M_RUN; m_cnt = 0; end else m_cnt++;
                M_RUN: if (stop_req) m_mode = M_SP; else if (wait_req) m_mode = M_WT;
                M_WT:  if (wake) m_mode = M_RUN;
                M_SP:  if (wake) begin m_mode = M_RC; m_cnt = 0; end
                M_RC:  if (m_cnt == STOPC - 1) begin m_mode = M_RUN; m_cnt = 0; end else m_cnt++;
                default: m_mode = M_ST;
            endcase
        end
    endtask

    task automatic step(input bit por, input bit lvi, input bit stp, input bit wt,
                        input bit wk, input bit sel, input logic [NP-1:0] wen, input string tag);
        @(negedge clk);
        por_req = por; lvi_req = lvi; stop_req = stp; wait_req = wt;
        wake = wk; src_sel_b = sel; periph_wait_en = wen;
        #1;
        chk(tag, "sys_rst", 32'(sys_rst), 32'(m_mode == M_ST));
        chk(tag, "cpu_en", 32'(cpu_en), 32'(exp_stb() && m_mode == M_RUN));
        chk(tag, "periph_en", 32'(periph_en), 32'(exp_periph()));
        @(posedge clk);
        model_update();
    endtask

    function automatic string mode_tag();
        case (m_mode)
            M_ST:  return "R3";
            M_RUN: return "R1";
            M_WT:  return "R7";
            M_SP:  return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        int seed_v;
        bit sel_r;
        seed_v = $urandom(32'd1357);
        @(posedge clk);
        // R3: reset hold length
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, 0, 1, '0, "R3");
        // R9: requests ignored while starting up
        for (int i = 0; i < 20; i++) step(0, 0, i[0], i[1], i[2], 1, '0, "R9");
        for (int i = 0; i < 14; i++) step(0, 0, 0, 0, 0, 1, '0, "R3");
        // R1: full-rate source, quarter-rate strobe
        for (int i = 0; i < 13; i++) step(0, 0, 0, 0, 0, 1, '0, "R1");
        // R9: wake in RUN ignored
        for (int i = 0; i < 5; i++) step(0, 0, 0, 0, 1, 1, '0, "R9");
        // R7: wait with mixed peripheral enables
        step(0, 0, 0, 1, 0, 1, 4'b0101, "R7");
        for (int i = 0; i < 12; i++) step(0, 0, 0, 0, 0, 1, 4'b0101, "R7");
        // R8: immediate return from wait
        step(0, 0, 0, 0, 1, 1, 4'b0101, "R8");
        for (int i = 0; i < 8; i++) step(0, 0, 0, 0, 0, 1, '0, "R8");
        // R5: stop beats wait
        step(0, 0, 1, 1, 0, 1, '1, "R5");
        for (int i = 0; i < 10; i++) step(0, 0, 0, 1, 0, 1, '1, "R5");
        // R6: recovery timeout then release
        step(0, 0, 0, 0, 1, 1, '0, "R6");
        for (int i = 0; i < 24; i++) step(0, 0, 0, 0, 0, 1, '0, "R6");
        // R10: low-voltage request from RUN
        step(0, 1, 0, 0, 0, 1, '0, "R10");
        // R4: restart in the middle of startup, switch to half-rate source
        for (int i = 0; i < 10; i++) step(0, 0, 0, 0, 0, 0, '0, "R4");
        step(1, 0, 0, 0, 0, 0, '0, "R4");
        for (int i = 0; i < 34; i++) step(0, 0, 0, 0, 0, 0, '0, "R4");
        // R2: half-rate source, strobe every 8 cycles
        for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 0, 0, '0, "R2");
        // R10: stop then reset request while stopped
        step(0, 0, 1, 0, 0, 0, '0, "R10");
        step(0, 0, 0, 0, 0, 0, '0, "R10");
        step(0, 1, 0, 0, 0, 0, '0, "R10");
        for (int i = 0; i < 40; i++) step(0, 0, 0, 0, 0, 0, '0, "R10");
        // random traffic
        sel_r = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            bit p  = ($urandom_range(0, 299) == 0);
            bit l  = ($urandom_range(0, 299) == 0);
            bit s  = ($urandom_range(0, 29) == 0);
            bit w  = ($urandom_range(0, 11) == 0);
            bit k  = ($urandom_range(0, 19) == 0);
            logic [NP-1:0] e = NP'($urandom);
            if (m_mode == M_ST && $urandom_range(0, 19) == 0) sel_r = ~sel_r;
            step(p, l, s, w, k, sel_r, e, mode_tag());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            n_bad++;
            $display("FAIL R3 watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule